// File: doc/BRIEF.md
# CAM Match Status and Next-Free Tracker

This block is a compact content-addressable store in which every location holds a data word and two validity bits: skip and empty. A masked compare runs the comparand against all locations in parallel. Only locations that are neither empty nor skipped can hit. A priority encoder then reports the lowest-numbered hit and notes when there is more than one. The block also tracks the lowest empty location as the next-free pointer, which is used for writes that do not name an address.

All results appear in a 32-bit status word with active-low flags. The word holds a full flag, a multiple-hit flag, the skip and empty bits of the last location read, a device page number, the hit address and a hit flag.

Several devices can be chained through an active-low full cascade. A device serves next-free accesses and shows its next-free address only when its full input is low and its own full output is still high. In a chain of devices, this means the first device that still has room.

Top module: `camStatusUnit`

## Requirements
- R1: After reset, every location is empty (skip 0, empty 1) and holds zero. The status word reads all ones except for the page field. The next-free address is 0, and the full output is high while the full input is low.
- R2: A read returns the location's data on `rdData` one clock after `rdEn`. At the same time, status bit 29 takes that location's skip bit and bit 28 takes its empty bit. Both bits stay 1 after reset until the first read, and they change only on reads.
- R3: A compare strobe registers its result by the next clock. Status bit 0 goes low when at least one eligible location is equal to the comparand in every bit where `cmpMask` is 0 (a mask bit of 1 excludes that bit). Bits [ADDR_W:1] then hold the lowest matching index. Match fields change only on a compare.
- R4: Status bit 30 goes low when two or more eligible locations match the same compare.
- R5: A location whose skip bit or empty bit is 1 never matches.
- R6: When a compare finds no match, bit 0 is 1, bit 30 is 1 and the match address field is all ones.
- R7: The next-free address is the lowest location with its empty bit set. It and the full flag take up a validity change in the clock after the write that made it.
- R8: Status bit 31 is low when no location is empty. `fullOutN` is low only when this device is full and `fullInN` is low.
- R9: A write with `wrToNf` set goes to the next-free address only when `fullInN` is low and `fullOutN` is high; otherwise it has no effect. `nfSel` is high exactly in that state, and `nfAddr` reads 0 when `nfSel` is low.
- R10: Status bits [27:ADDR_W+1] always show the `pageAddr` input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write strobe |
| wrToNf | input | 1 | Write goes to the next-free address instead of wrAddr |
| wrAddr | input | ADDR_W | Explicit write address |
| wrData | input | DATA_W | Data to store |
| wrSkip | input | 1 | Skip bit to store |
| wrEmpty | input | 1 | Empty bit to store |
| cmpStrobe | input | 1 | Start a compare |
| comparand | input | DATA_W | Value to search for |
| cmpMask | input | DATA_W | Per-bit exclusion from the compare (1 = ignore) |
| rdEn | input | 1 | Read strobe |
| rdAddr | input | ADDR_W | Read address |
| rdData | output | DATA_W | Data of the last location read |
| pageAddr | input | 27-ADDR_W | Device page number reported in status |
| fullInN | input | 1 | Full cascade input, active low |
| fullOutN | output | 1 | Full cascade output, active low |
| nfSel | output | 1 | This device serves next-free accesses |
| nfAddr | output | ADDR_W | Next-free address, zero when not selected |
| statusWord | output | 32 | Status word |

## Verification
The hardest state to reach is a full device that loses exactly one empty location. The test must observe the one-clock lag before the full flag and the next-free pointer recover, and then show that a next-free write with the cascade input high changes nothing. The bench fills every location through next-free writes, then clears single locations with explicit writes. It samples the full flag in the clock right after the write and again one clock later. It then toggles the cascade input and reads the target location back.

// File: rtl/camStatusPkg.sv
package camStatusPkg;

  localparam int STATUS_W = 32;
  localparam int FULL_POS = 31;
  localparam int MULTI_POS = 30;
  localparam int SKIP_POS = 29;
  localparam int EMPTY_POS = 28;
  localparam int HIT_POS = 0;

  // strobes from control to datapath
  typedef struct packed {
    logic doWrite;
    logic writeToNf;
    logic doCompare;
    logic doRead;
  } ctlStrobes_t;

endpackage

// File: rtl/camPrioEnc.sv
module camPrioEnc #(
  parameter int N = 16,
  parameter int AW = 4
) (
  input  logic [N-1:0]  req,
  output logic          anyReq,
  output logic [AW-1:0] idx
);

  // lowest index wins: scan from the top so the last assignment is the lowest
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = AW'(i);
    end
  end

  assign anyReq = |req;

endmodule

// File: rtl/camStatusCtrl.sv
module camStatusCtrl
  import camStatusPkg::*;
(
  input  logic        wrEn,
  input  logic        wrToNf,
  input  logic        cmpStrobe,
  input  logic        rdEn,
  input  logic        fullInN,
  input  logic        localFull,
  output ctlStrobes_t strb,
  output logic        nfSelect,
  output logic        fullOutN
);

  // this device is the active next-free target when upstream is full and it is not
  assign nfSelect = !fullInN && !localFull;
  assign fullOutN = !(!fullInN && localFull);

  always_comb begin
    strb.writeToNf = wrToNf;
    strb.doWrite = wrEn && (!wrToNf || nfSelect);
    strb.doCompare = cmpStrobe;
    strb.doRead = rdEn;
  end

endmodule

// File: rtl/camStatusDatapath.sv
module camStatusDatapath
  import camStatusPkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DATA_W = 64,
  parameter int ADDR_W = 4,
  parameter int PAGE_W = 23
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobes_t         strb,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [DATA_W-1:0]   wrData,
  input  logic                wrSkip,
  input  logic                wrEmpty,
  input  logic [DATA_W-1:0]   comparand,
  input  logic [DATA_W-1:0]   cmpMask,
  input  logic [ADDR_W-1:0]   rdAddr,
  input  logic [PAGE_W-1:0]   pageAddr,
  output logic [DATA_W-1:0]   rdData,
  output logic [STATUS_W-1:0] statusWord,
  output logic [ADDR_W-1:0]   nextFree,
  output logic                localFull
);

  logic [DATA_W-1:0] memData [DEPTH];
  logic [DEPTH-1:0]  skipBit;
  logic [DEPTH-1:0]  emptyBit;
  logic [DEPTH-1:0]  hitVec;
  logic [ADDR_W-1:0] wrTarget;

  logic              hitAny;
  logic              hitMulti;
  logic [ADDR_W-1:0] hitIdx;
  logic              freeAny;
  logic [ADDR_W-1:0] freeIdx;

  logic              matchHitQ;
  logic              multiQ;
  logic [ADDR_W-1:0] matchAddrQ;
  logic              lastSkipQ;
  logic              lastEmptyQ;
  logic [DATA_W-1:0] rdDataQ;
  logic [ADDR_W-1:0] nextFreeQ;
  logic              fullQ;

  assign wrTarget = strb.writeToNf ? nextFreeQ : wrAddr;

  // storage and validity bits
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) memData[i] <= '0;
      skipBit <= '0;
      emptyBit <= '1;
    end else if (strb.doWrite) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (wrTarget == ADDR_W'(i)) begin
          memData[i] <= wrData;
          skipBit[i] <= wrSkip;
          emptyBit[i] <= wrEmpty;
        end
      end
    end
  end

  // per-entry masked compare, qualified by validity
  for (genvar g = 0; g < DEPTH; g++) begin : gHit
    assign hitVec[g] = !skipBit[g] && !emptyBit[g] &&
                       (((memData[g] ^ comparand) & ~cmpMask) == '0);
  end

  assign hitMulti = (hitVec & (hitVec - DEPTH'(1))) != '0;

  camPrioEnc #(.N(DEPTH), .AW(ADDR_W)) uMatchEnc (
    .req(hitVec), .anyReq(hitAny), .idx(hitIdx)
  );

  camPrioEnc #(.N(DEPTH), .AW(ADDR_W)) uFreeEnc (
    .req(emptyBit), .anyReq(freeAny), .idx(freeIdx)
  );

  // compare result registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      matchHitQ <= 1'b0;
      multiQ <= 1'b0;
      matchAddrQ <= '1;
    end else if (strb.doCompare) begin
      matchHitQ <= hitAny;
      multiQ <= hitMulti;
      matchAddrQ <= hitAny ? hitIdx : '1;
    end
  end

  // read path and last-read validity
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdDataQ <= '0;
      lastSkipQ <= 1'b1;
      lastEmptyQ <= 1'b1;
    end else if (strb.doRead) begin
      if (int'(rdAddr) < DEPTH) begin
        rdDataQ <= memData[rdAddr];
        lastSkipQ <= skipBit[rdAddr];
        lastEmptyQ <= emptyBit[rdAddr];
      end else begin
        rdDataQ <= '0;
        lastSkipQ <= 1'b1;
        lastEmptyQ <= 1'b1;
      end
    end
  end

  // next-free pointer and full flag trail the validity bits by one clock
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nextFreeQ <= '0;
      fullQ <= 1'b0;
    end else begin
      nextFreeQ <= freeIdx;
      fullQ <= !freeAny;
    end
  end

  assign rdData = rdDataQ;
  assign nextFree = nextFreeQ;
  assign localFull = fullQ;
  assign statusWord = {~fullQ, ~multiQ, lastSkipQ, lastEmptyQ,
                       pageAddr, matchAddrQ, ~matchHitQ};

endmodule

// File: rtl/camStatusUnit.sv
module camStatusUnit
  import camStatusPkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DATA_W = 64,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int PAGE_W = 27 - ADDR_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic                wrToNf,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [DATA_W-1:0]   wrData,
  input  logic                wrSkip,
  input  logic                wrEmpty,
  input  logic                cmpStrobe,
  input  logic [DATA_W-1:0]   comparand,
  input  logic [DATA_W-1:0]   cmpMask,
  input  logic                rdEn,
  input  logic [ADDR_W-1:0]   rdAddr,
  output logic [DATA_W-1:0]   rdData,
  input  logic [PAGE_W-1:0]   pageAddr,
  input  logic                fullInN,
  output logic                fullOutN,
  output logic                nfSel,
  output logic [ADDR_W-1:0]   nfAddr,
  output logic [STATUS_W-1:0] statusWord
);

  ctlStrobes_t       strb;
  logic              localFull;
  logic [ADDR_W-1:0] nextFree;

  camStatusCtrl uCtrl (
    .wrEn(wrEn),
    .wrToNf(wrToNf),
    .cmpStrobe(cmpStrobe),
    .rdEn(rdEn),
    .fullInN(fullInN),
    .localFull(localFull),
    .strb(strb),
    .nfSelect(nfSel),
    .fullOutN(fullOutN)
  );

  camStatusDatapath #(
    .DEPTH(DEPTH), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PAGE_W(PAGE_W)
  ) uDp (
    .clk(clk),
    .rstN(rstN),
    .strb(strb),
    .wrAddr(wrAddr),
    .wrData(wrData),
    .wrSkip(wrSkip),
    .wrEmpty(wrEmpty),
    .comparand(comparand),
    .cmpMask(cmpMask),
    .rdAddr(rdAddr),
    .pageAddr(pageAddr),
    .rdData(rdData),
    .statusWord(statusWord),
    .nextFree(nextFree),
    .localFull(localFull)
  );

  assign nfAddr = nfSel ? nextFree : '0;

endmodule

// File: rtl/camStatusChecker.sv
module camStatusChecker #(
  parameter int ADDR_W = 4
) (
  input logic        clk,
  input logic        rstN,
  input logic        cmpStrobe,
  input logic        rdEn,
  input logic        fullInN,
  input logic        fullOutN,
  input logic        nfSel,
  input logic [31:0] statusWord
);

  // R9: selection only with cascade input low and own full output high
  a_r9_nf_select: assert property (@(posedge clk) disable iff (!rstN)
    nfSel |-> (!fullInN && fullOutN));

  // R8: a high cascade input always passes through as high
  a_r8_chain_pass: assert property (@(posedge clk) disable iff (!rstN)
    fullInN |-> fullOutN);

  // R6: no hit means an all-ones match address
  a_r6_nomatch_ones: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[0] |-> (statusWord[ADDR_W:1] == '1));

  // R4: multiple hits imply a hit
  a_r4_multi_has_hit: assert property (@(posedge clk) disable iff (!rstN)
    !statusWord[30] |-> !statusWord[0]);

  // R3: match fields hold without a compare
  a_r3_hold_no_cmp: assert property (@(posedge clk) disable iff (!rstN)
    !cmpStrobe |=> $stable({statusWord[30], statusWord[ADDR_W:0]}));

  // R2: last-read validity holds without a read
  a_r2_hold_no_read: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(statusWord[29:28]));

endmodule

bind camStatusUnit camStatusChecker #(.ADDR_W(ADDR_W)) uChk (
  .clk(clk),
  .rstN(rstN),
  .cmpStrobe(cmpStrobe),
  .rdEn(rdEn),
  .fullInN(fullInN),
  .fullOutN(fullOutN),
  .nfSel(nfSel),
  .statusWord(statusWord)
);

// File: tb/tb_camStatusUnit.sv
module tb_camStatusUnit;

  localparam int DEPTH = 16;
  localparam int AW = 4;
  localparam int PW = 27 - AW;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rstN = 1'b0;
  logic          wrEn = 1'b0, wrToNf = 1'b0, wrSkip = 1'b0, wrEmpty = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic [63:0]   wrData = '0;
  logic          cmpStrobe = 1'b0;
  logic [63:0]   comparand = '0, cmpMask = '0;
  logic          rdEn = 1'b0;
  logic [AW-1:0] rdAddr = '0;
  logic [63:0]   rdData;
  logic [PW-1:0] pageAddr = 23'h5A3C1;
  logic          fullInN = 1'b0;
  logic          fullOutN, nfSel;
  logic [AW-1:0] nfAddr;
  logic [31:0]   statusWord;

  camStatusUnit #(.DEPTH(DEPTH), .DATA_W(64)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrToNf(wrToNf), .wrAddr(wrAddr),
    .wrData(wrData), .wrSkip(wrSkip), .wrEmpty(wrEmpty),
    .cmpStrobe(cmpStrobe), .comparand(comparand), .cmpMask(cmpMask),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData), .pageAddr(pageAddr),
    .fullInN(fullInN), .fullOutN(fullOutN), .nfSel(nfSel), .nfAddr(nfAddr),
    .statusWord(statusWord)
  );

  int nChecks = 0;
  int nFail = 0;

  // reference model
  logic [63:0]   mData [DEPTH];
  logic          mSkip [DEPTH];
  logic          mEmpty [DEPTH];
  logic          eHit = 1'b0, eMulti = 1'b0;
  logic [AW-1:0] eAddr = '1;
  logic          eLs = 1'b1, eLe = 1'b1;

  function automatic logic [63:0] dataOf(int i);
    return 64'h0123_4567_89AB_CDEF ^ (64'(i) * 64'h0001_0010_0100_1003);
  endfunction

  function automatic int firstEmpty();
    for (int i = 0; i < DEPTH; i++) if (mEmpty[i]) return i;
    return -1;
  endfunction

  function automatic logic [31:0] expStatus();
    logic notFull;
    notFull = (firstEmpty() >= 0);
    return {notFull, ~eMulti, eLs, eLe, pageAddr,
            (eHit ? eAddr : {AW{1'b1}}), ~eHit};
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
  endtask

  task automatic doWr(logic toNf, logic [AW-1:0] a, logic [63:0] d, logic s, logic e);
    int tgt;
    wrEn = 1'b1; wrToNf = toNf; wrAddr = a; wrData = d; wrSkip = s; wrEmpty = e;
    if (toNf) tgt = (!fullInN && firstEmpty() >= 0) ? firstEmpty() : -1;
    else tgt = int'(a);
    @(negedge clk);
    wrEn = 1'b0; wrToNf = 1'b0;
    if (tgt >= 0) begin
      mData[tgt] = d; mSkip[tgt] = s; mEmpty[tgt] = e;
    end
    @(negedge clk);
  endtask

  task automatic doCmp(logic [63:0] c, logic [63:0] m);
    int cnt;
    cmpStrobe = 1'b1; comparand = c; cmpMask = m;
    @(negedge clk);
    cmpStrobe = 1'b0;
    cnt = 0; eAddr = '1;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!mSkip[i] && !mEmpty[i] && (((mData[i] ^ c) & ~m) == 64'h0)) begin
        cnt++; eAddr = AW'(i);
      end
    end
    eHit = (cnt > 0); eMulti = (cnt > 1);
    @(negedge clk);
  endtask

  task automatic doRd(int a);
    rdEn = 1'b1; rdAddr = AW'(a);
    @(negedge clk);
    rdEn = 1'b0;
    eLs = mSkip[a]; eLe = mEmpty[a];
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mData[i] = '0; mSkip[i] = 1'b0; mEmpty[i] = 1'b1;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 status", statusWord, {4'hF, pageAddr, 4'hF, 1'b1});
    check("R1 nfAddr", nfAddr, 0);
    check("R1 fullOutN", fullOutN, 1);
    check("R1 nfSel", nfSel, 1);

    // R7 fill every location via next-free writes
    for (int i = 0; i < DEPTH; i++) begin
      check("R7 nfAddr during fill", nfAddr, i);
      doWr(1'b1, '0, dataOf(i), 1'b0, 1'b0);
      check("R8 status during fill", statusWord, expStatus());
    end
    check("R8 full flag", statusWord[31], 0);
    check("R8 fullOutN full", fullOutN, 0);
    check("R9 nfSel full", nfSel, 0);
    check("R9 nfAddr full", nfAddr, 0);

    // R9 next-free write while full is ignored
    doWr(1'b1, '0, 64'hDEAD_BEEF_0000_0001, 1'b0, 1'b0);
    for (int i = 0; i < DEPTH; i++) begin
      doRd(i);
      check("R2 rdData", rdData, mData[i]);
      check("R2 status", statusWord, expStatus());
    end

    // R3 single-hit sweep
    for (int j = 0; j < DEPTH; j++) begin
      doCmp(dataOf(j), 64'h0);
      check("R3 sweep status", statusWord, expStatus());
      check("R3 sweep addr", statusWord[AW:1], j);
    end

    // R4 duplicate value
    doWr(1'b0, 4'd9, dataOf(5), 1'b0, 1'b0);
    doCmp(dataOf(5), 64'h0);
    check("R4 multi flag", statusWord[30], 0);
    check("R4 lowest addr", statusWord[AW:1], 5);

    // R3 masking
    doCmp(64'h0, '1);
    check("R3 mask all", statusWord, expStatus());
    check("R3 mask all addr", statusWord[AW:1], 0);
    doCmp(dataOf(3) ^ 64'h0000_0000_0000_FF00, 64'h0000_0000_0000_FF00);
    check("R3 partial mask", statusWord, expStatus());
    check("R3 partial mask addr", statusWord[AW:1], 3);

    // R5 skip excludes a location; R6 no-match encoding
    doWr(1'b0, 4'd0, dataOf(0), 1'b1, 1'b0);
    doCmp(dataOf(0), 64'h0);
    check("R6 no match", statusWord[AW:0], 5'h1F);
    check("R6 multi clear", statusWord[30], 1);
    doCmp(64'h0, '1);
    check("R5 skip not hit", statusWord[AW:1], 1);

    // R7 one-clock lag after clearing location 1
    wrEn = 1'b1; wrAddr = 4'd1; wrData = dataOf(1); wrSkip = 1'b0; wrEmpty = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
    mEmpty[1] = 1'b1;
    check("R7 full still low", statusWord[31], 0);
    @(negedge clk);
    check("R7 full released", statusWord[31], 1);
    check("R7 nfAddr", nfAddr, 1);
    check("R8 fullOutN released", fullOutN, 1);
    doRd(1);
    check("R2 empty read bits", statusWord[29:28], 2'b01);
    doCmp(dataOf(1), 64'h0);
    check("R5 empty not hit", statusWord, expStatus());

    // R9 next-free write accepted
    doWr(1'b1, '0, dataOf(20), 1'b0, 1'b0);
    doRd(1);
    check("R9 nf write data", rdData, dataOf(20));
    check("R9 nf write bits", statusWord[29:28], 2'b00);

    // R9 cascade input high blocks next-free access
    doWr(1'b0, 4'd3, dataOf(3), 1'b0, 1'b1);
    fullInN = 1'b1;
    @(negedge clk);
    check("R9 nfSel blocked", nfSel, 0);
    check("R9 nfAddr blocked", nfAddr, 0);
    check("R8 fullOutN pass", fullOutN, 1);
    doWr(1'b1, '0, dataOf(30), 1'b0, 1'b0);
    fullInN = 1'b0;
    @(negedge clk);
    doRd(3);
    check("R9 ignored data", rdData, dataOf(3));
    check("R9 ignored bits", statusWord[29:28], 2'b01);
    check("R9 nfAddr after", nfAddr, 3);

    // R8 cascade while full
    doWr(1'b1, '0, dataOf(33), 1'b0, 1'b0);
    fullInN = 1'b1;
    @(negedge clk);
    check("R8 full, input high", fullOutN, 1);
    check("R8 internal full", statusWord[31], 0);
    fullInN = 1'b0;
    @(negedge clk);
    check("R8 full, input low", fullOutN, 0);

    // R10 page field follows input
    pageAddr = 23'h12345;
    @(negedge clk);
    check("R10 page", statusWord[27:AW+1], 23'h12345);

    // R3 final sweep with several masks
    for (int j = 0; j < DEPTH; j++) begin
      doCmp(mData[j], 64'h0);
      check("R3 final exact", statusWord, expStatus());
      doCmp(mData[j] ^ 64'h0000_0000_0000_FFFF, 64'h0000_0000_0000_FFFF);
      check("R3 final low mask", statusWord, expStatus());
      doCmp(64'h5555_0000_0000_0000 ^ mData[j], 64'hFFFF_0000_0000_0000);
      check("R3 final high mask", statusWord, expStatus());
    end

    summary();
    $finish;
  end

endmodule